// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit computes the 24-bit operand or branch address for a 16-bit processor core whose program counter is 24 bits wide. It takes the raw address or displacement field from an instruction, the address of the instruction that follows, an addressing-mode select, a field-size select and an address-space mode bit. It returns the effective address and a flag that marks an odd branch target.

Absolute addresses come in three widths. The short (8-bit) form is one-extended, so it lands in the top 256 bytes of memory. The medium (16-bit) form is sign-extended, so it covers the bottom 32 KB and the top 32 KB. The long (24-bit) form reaches every byte. In PC-relative mode the displacement is sign-extended and added to the next-instruction address. In the narrow address space (1-Mbyte) every result is cut to 20 bits.

The address path is combinational. A parameter picks whether a pipeline register follows it; by default the register is present.

Top module: `eag_unit`

## Requirements
- R1: Absolute short (mode_sel=0, size_sel=0) uses field[7:0] and yields H'FFFFxx in wide mode (space_1m=0) and H'0FFFxx in narrow mode (space_1m=1).
- R2: Absolute medium (mode_sel=0, size_sel=1) sign-extends field[15:0]: H'0000..H'7FFF give H'000000..H'007FFF, and H'8000..H'FFFF give H'FF8000..H'FFFFFF (wide) or H'0F8000..H'0FFFFF (narrow).
- R3: Absolute long (mode_sel=0, size_sel=2 or 3) passes all 24 bits of field through unchanged in wide mode.
- R4: PC-relative (mode_sel=1) adds next_pc to the displacement: field[7:0] sign-extended for size_sel=0, field[15:0] sign-extended for size_sel=1, and all of field[23:0] for size_sel=2 or 3.
- R5: PC-relative sums wrap modulo 2^24 in wide mode and modulo 2^20 in narrow mode, with no overflow indication.
- R6: odd_target is 1 exactly when mode_sel=1 and bit 0 of the resulting address is 1; it is 0 for every absolute mode.
- R7: In narrow mode (space_1m=1) bits 23:20 of ea_out are 0 for every mode and size.
- R8: With the output register present, ea_out and odd_target show the result for the inputs sampled at a rising clk edge where in_valid=1, and out_valid is 1, from that edge until the next.
- R9: At a rising edge with in_valid=0, ea_out and odd_target keep their values and out_valid becomes 0, whatever the other inputs are.
- R10: A rising edge with rst_n=0 sets ea_out to 0, odd_target to 0 and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs are valid this cycle; the result is captured |
| mode_sel | input | 1 | 0 = absolute, 1 = PC-relative |
| size_sel | input | 2 | 0 = 8-bit field, 1 = 16-bit field, 2 or 3 = 24-bit field |
| field | input | 24 | Address or displacement field from the instruction |
| next_pc | input | 24 | Address of the first byte of the next instruction |
| space_1m | input | 1 | 1 = 20-bit (1-Mbyte) space, 0 = 24-bit (16-Mbyte) space |
| ea_out | output | 24 | Effective address |
| odd_target | output | 1 | PC-relative target address is odd |
| out_valid | output | 1 | ea_out and odd_target hold a freshly captured result |

## Verification
Every result is due exactly one clock after the rising edge that samples in_valid=1 with the inputs. No other register stands between the inputs and the outputs, so nothing shows up later than that. The bench changes inputs on the falling edge, waits for the next rising edge, and then samples 1 ns later. Each output is therefore read only once the capturing edge has settled, and never during the edge itself. The hold and reset checks use the same one-edge timing and look at the outputs before any new input is given.

// File: rtl/eag_pkg.sv
// Shared encodings for the effective address generation unit.
// Assumes: mode and size selects arrive already decoded from the instruction.
package eag_pkg;

    typedef enum logic {
        EA_ABS   = 1'b0,
        EA_PCREL = 1'b1
    } ea_mode_e;

    typedef enum logic [1:0] {
        SZ_SHORT    = 2'd0,
        SZ_MEDIUM   = 2'd1,
        SZ_LONG     = 2'd2,
        SZ_LONG_ALT = 2'd3
    } ea_size_e;

endpackage

// File: rtl/eag_extend.sv
// Widens the instruction field to a full address word.
// Short absolute fields are one-extended into the top of memory. Short
// displacements and all medium fields are sign-extended. Long fields pass through.
// Assumes: SHORT_W < MED_W < AW.
module eag_extend
    import eag_pkg::*;
#(
    parameter int AW      = 24,
    parameter int SHORT_W = 8,
    parameter int MED_W   = 16
) (
    input  ea_mode_e          mode,
    input  ea_size_e          size,
    input  logic [AW-1:0]     field,
    output logic [AW-1:0]     ext
);

    localparam int SHORT_PAD = AW - SHORT_W;
    localparam int MED_PAD   = AW - MED_W;

    logic [AW-1:0] short_ones;
    logic [AW-1:0] short_sign;
    logic [AW-1:0] med_sign;

    // Candidate extensions of the field, one per field width
    always_comb begin
        short_ones = {{SHORT_PAD{1'b1}}, field[SHORT_W-1:0]};
        short_sign = {{SHORT_PAD{field[SHORT_W-1]}}, field[SHORT_W-1:0]};
        med_sign   = {{MED_PAD{field[MED_W-1]}}, field[MED_W-1:0]};
    end

    // Pick the extension that the size and mode call for
    always_comb begin
        unique case (size)
            SZ_SHORT:  ext = (mode == EA_ABS) ? short_ones : short_sign;
            SZ_MEDIUM: ext = med_sign;
            default:   ext = field;
        endcase
    end

endmodule

// File: rtl/eag_calc.sv
// Forms the address from the extended field: for absolute modes it is the field
// itself, for PC-relative it is next_pc plus the displacement, wrapping.
// It then masks the result to the narrow space when that mode is chosen,
// and flags an odd PC-relative target.
// Assumes: NW < AW.
module eag_calc
    import eag_pkg::*;
#(
    parameter int AW = 24,
    parameter int NW = 20
) (
    input  ea_mode_e          mode,
    input  logic              narrow,
    input  logic [AW-1:0]     ext,
    input  logic [AW-1:0]     next_pc,
    output logic [AW-1:0]     ea,
    output logic              odd
);

    localparam logic [AW-1:0] NARROW_MASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

    logic [AW-1:0] sum;
    logic [AW-1:0] raw;

    // Modulo-2^AW addition of base and displacement; carry out discarded
    always_comb sum = next_pc + ext;

    // Choose absolute field or relative sum
    always_comb raw = (mode == EA_PCREL) ? sum : ext;

    // Clip to the narrow space and derive the alignment flag
    always_comb begin
        ea  = narrow ? (raw & NARROW_MASK) : raw;
        odd = (mode == EA_PCREL) && ea[0];
    end

endmodule

// File: rtl/eag_out_stage.sv
// Optional output register. With REG_OUT=1 it captures the result on a clock
// edge with valid high and holds it otherwise. With REG_OUT=0 it is wires.
// Assumes: synchronous active-low reset.
module eag_out_stage #(
    parameter int AW      = 24,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_in,
    input  logic [AW-1:0] ea_in,
    input  logic          odd_in,
    output logic [AW-1:0] ea_q,
    output logic          odd_q,
    output logic          vld_q
);

    if (REG_OUT) begin : g_reg
        // Capture result on valid, hold on idle, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ea_q  <= '0;
                odd_q <= 1'b0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= vld_in;
                if (vld_in) begin
                    ea_q  <= ea_in;
                    odd_q <= odd_in;
                end
            end
        end
    end else begin : g_wire
        // Pass the combinational result straight through
        always_comb begin
            ea_q  = ea_in;
            odd_q = odd_in;
            vld_q = vld_in;
        end
    end

endmodule

// File: rtl/eag_unit.sv
// Top of the effective address generation unit. It extends the field,
// computes the absolute or PC-relative address, clips it to the active
// address space, and optionally registers the result.
// Assumes: inputs are steady around the clock edge at which in_valid is high.
module eag_unit
    import eag_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int NARROW_W = 20,
    parameter int SHORT_W  = 8,
    parameter int MED_W    = 16,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode_sel,
    input  logic [1:0]        size_sel,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              space_1m,
    output logic [ADDR_W-1:0] ea_out,
    output logic              odd_target,
    output logic              out_valid
);

    ea_mode_e          mode;
    ea_size_e          size;
    logic [ADDR_W-1:0] ext;
    logic [ADDR_W-1:0] ea_c;
    logic              odd_c;

    // Map raw select pins onto the shared encodings
    always_comb begin
        mode = ea_mode_e'(mode_sel);
        size = ea_size_e'(size_sel);
    end

    eag_extend #(
        .AW      (ADDR_W),
        .SHORT_W (SHORT_W),
        .MED_W   (MED_W)
    ) u_ext (
        .mode  (mode),
        .size  (size),
        .field (field),
        .ext   (ext)
    );

    eag_calc #(
        .AW (ADDR_W),
        .NW (NARROW_W)
    ) u_calc (
        .mode    (mode),
        .narrow  (space_1m),
        .ext     (ext),
        .next_pc (next_pc),
        .ea      (ea_c),
        .odd     (odd_c)
    );

    eag_out_stage #(
        .AW      (ADDR_W),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_in (in_valid),
        .ea_in  (ea_c),
        .odd_in (odd_c),
        .ea_q   (ea_out),
        .odd_q  (odd_target),
        .vld_q  (out_valid)
    );

    if (REG_OUT) begin : g_chk
        // R1
        short_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !mode_sel && size_sel == 2'd0 && !space_1m)
            |=> ea_out[ADDR_W-1:SHORT_W] == '1);

        // R7
        narrow_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && space_1m) |=> ea_out[ADDR_W-1:NARROW_W] == '0);

        // R6
        abs_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !mode_sel) |=> !odd_target);

        // R8
        valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        // R9
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(ea_out) && $stable(odd_target) && !out_valid));
    end

endmodule

// File: tb/sim_eag_unit.sv
module sim_eag_unit;

    typedef struct packed {
        logic        pc;
        logic [1:0]  sz;
        logic        m1;
        logic [23:0] fld;
        logic [23:0] npc;
        logic [23:0] ea;
        logic        odd;
    } vec_t;

    localparam int NV = 15;
    // {pcrel, size, narrow, field, next_pc, expected ea, expected odd}
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 24'h000012, 24'h000000, 24'hFFFF12, 1'b0}, // R1
        '{1'b0, 2'd0, 1'b1, 24'hABCD80, 24'h000000, 24'h0FFF80, 1'b0}, // R1 R7
        '{1'b0, 2'd1, 1'b0, 24'h007FFF, 24'h000000, 24'h007FFF, 1'b0}, // R2
        '{1'b0, 2'd1, 1'b0, 24'h008000, 24'h000000, 24'hFF8000, 1'b0}, // R2
        '{1'b0, 2'd1, 1'b1, 24'h12FFFF, 24'h000000, 24'h0FFFFF, 1'b0}, // R2 R7
        '{1'b0, 2'd2, 1'b0, 24'hABCDEF, 24'h000000, 24'hABCDEF, 1'b0}, // R3
        '{1'b0, 2'd3, 1'b1, 24'hABCDEF, 24'h000000, 24'h0BCDEF, 1'b0}, // R3 R7
        '{1'b1, 2'd0, 1'b0, 24'h000080, 24'h001000, 24'h000F80, 1'b0}, // R4
        '{1'b1, 2'd0, 1'b0, 24'h55AA7F, 24'h001000, 24'h00107F, 1'b1}, // R4 R6
        '{1'b1, 2'd1, 1'b0, 24'h008002, 24'h010000, 24'h008002, 1'b0}, // R4
        '{1'b1, 2'd1, 1'b0, 24'h007FFF, 24'h000001, 24'h008000, 1'b0}, // R4
        '{1'b1, 2'd0, 1'b0, 24'h000010, 24'hFFFFF8, 24'h000008, 1'b0}, // R5
        '{1'b1, 2'd0, 1'b1, 24'h0000F0, 24'h000004, 24'h0FFFF4, 1'b0}, // R5 R7
        '{1'b1, 2'd2, 1'b0, 24'h100000, 24'h000002, 24'h100002, 1'b0}, // R4
        '{1'b1, 2'd1, 1'b1, 24'h000002, 24'h0FFFFF, 24'h000001, 1'b1}  // R5 R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode_sel = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic [23:0] field = '0;
    logic [23:0] next_pc = '0;
    logic        space_1m = 1'b0;
    logic [23:0] ea_out;
    logic        odd_target;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eag_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mode_sel   (mode_sel),
        .size_sel   (size_sel),
        .field      (field),
        .next_pc    (next_pc),
        .space_1m   (space_1m),
        .ea_out     (ea_out),
        .odd_target (odd_target),
        .out_valid  (out_valid)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at falling edge, let one rising edge capture, sample 1 ns after it
    task automatic apply(input logic v, input logic pc, input logic [1:0] sz,
                         input logic m1, input logic [23:0] fld, input logic [23:0] npc);
        @(negedge clk);
        in_valid = v; mode_sel = pc; size_sel = sz; space_1m = m1;
        field = fld; next_pc = npc;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 ea", ea_out, 24'h0);
        chk("R10 odd", {23'b0, odd_target}, 24'h0);
        chk("R10 valid", {23'b0, out_valid}, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R1..R7 with R8 timing
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VECS[i].pc, VECS[i].sz, VECS[i].m1, VECS[i].fld, VECS[i].npc);
            chk($sformatf("R1-7 vec%0d ea", i), ea_out, VECS[i].ea);
            chk($sformatf("R6 vec%0d odd", i), {23'b0, odd_target}, {23'b0, VECS[i].odd});
            chk($sformatf("R8 vec%0d valid", i), {23'b0, out_valid}, 24'h1);
        end

        // R9: idle cycle holds the last result (odd one) and drops valid
        apply(1'b1, 1'b1, 2'd0, 1'b0, 24'h000001, 24'h000100);
        chk("R6 odd short", {23'b0, odd_target}, 24'h1);
        apply(1'b0, 1'b0, 2'd2, 1'b0, 24'h123456, 24'h000000);
        chk("R9 hold ea", ea_out, 24'h000101);
        chk("R9 hold odd", {23'b0, odd_target}, 24'h1);
        chk("R9 valid low", {23'b0, out_valid}, 24'h0);

        // R8: one idle then a new capture shows up after exactly one edge
        apply(1'b1, 1'b0, 2'd1, 1'b0, 24'h00FFFE, 24'h000000);
        chk("R8 recapture ea", ea_out, 24'hFFFFFE);
        chk("R8 recapture valid", {23'b0, out_valid}, 24'h1);

        // R10: reset in mid-run while valid input is present
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1; mode_sel = 1'b1; size_sel = 2'd0; field = 24'h000001;
        @(posedge clk);
        #1;
        chk("R10 mid ea", ea_out, 24'h0);
        chk("R10 mid odd", {23'b0, odd_target}, 24'h0);
        chk("R10 mid valid", {23'b0, out_valid}, 24'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule